// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits beside a processor core and decides, in the same cycle as the access, whether an instruction fetch or a data load/store is allowed. It holds two independent region tables: one for instruction space and one for data space. Each can have up to 32 entries. Every region has a base address on a 64-byte grain and an extent. An elaboration parameter chooses how the extent is given. In limit mode it is an exclusive upper address. In size mode it is a power-of-two size whose base is aligned to that size. Each region also carries an enable bit and permission bits. Instruction regions carry execute permission. Data regions carry separate read and write permission.

Regions may overlap. When more than one region matches, the lowest-numbered matching region decides the permission. An access that matches no enabled region is refused. No bypass mode exists: from reset, every region is disabled, so every checked access faults until software programs the tables. The tables are written through a simple register port that takes a table select, a region index, a field select and a 32-bit word. A write takes effect at the next clock edge. The lookup itself is purely combinational.

Top module: `region_guard`

## Requirements
- R1: After reset all regions of both tables are disabled, so every access reports hit=0, and every valid access reports fault=1 until a region is programmed.
- R2: Fetches are checked only against the instruction table, and loads and stores only against the data table (cfg_dside=0 writes the instruction table, cfg_dside=1 writes the data table).
- R3: In limit mode (BOUND_MODE=BOUND_LIMIT) a region matches when {base[31:6],6'b0} <= address < bound, with the bound taken as a full 32-bit address.
- R4: In size mode (BOUND_MODE=BOUND_SIZE) bound[5:0] is log2 of the region size. Values below 6 are treated as 6, and values of 32 or more cover the whole address space. A region matches when the address and the base agree on all bits above that size.
- R5: When several enabled regions match, the outputs report the lowest-numbered one in the idx outputs, and that region's permission bits decide the fault.
- R6: An access that matches no enabled region reports hit=0 and idx=0, and it faults when valid.
- R7: The control word holds enable in bit 0, read/execute in bit 1 and write in bit 2. A fetch needs bit 1, a load needs bit 1 and a store (dat_store=1) needs bit 2. A matched access that lacks the needed bit faults.
- R8: A region whose enable bit is 0 never matches, whatever its other fields hold.
- R9: Field select codes are: 0 for base, 1 for bound and 2 for control. Code 3, and any region index at or above the table depth, are ignored.
- R10: The hit and idx outputs follow the address combinationally in the same cycle. The fault output is 0 whenever its valid input is 0.
- R11: A configuration write changes the lookup result only from the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dside | input | 1 | Table select: 0 instruction, 1 data |
| cfg_idx | input | 5 | Region index to write |
| cfg_fld | input | 2 | Field select: 0 base, 1 bound, 2 control, 3 ignored |
| cfg_wdata | input | 32 | Write data |
| ins_valid | input | 1 | Fetch check request |
| ins_addr | input | 32 | Fetch address |
| ins_hit | output | 1 | Some enabled instruction region matches |
| ins_fault | output | 1 | Fetch refused |
| ins_idx | output | 5 | Lowest matching instruction region |
| dat_valid | input | 1 | Load/store check request |
| dat_store | input | 1 | 1 store, 0 load |
| dat_addr | input | 32 | Data address |
| dat_hit | output | 1 | Some enabled data region matches |
| dat_fault | output | 1 | Load/store refused |
| dat_idx | output | 5 | Lowest matching data region |

## Verification
The assertions check several rules on every cycle. An idle port never faults. A miss always faults and reports index zero. A reported index lies inside the table. Nothing matches in the cycle after reset. Without a configuration write, the lookup result for an unchanged address does not move. Only the bench's scenarios can show the following behaviours:

- the exact address bounds in each bound mode, including clamped and whole-space sizes;
- lowest-index priority among overlapping regions;
- the separate read, write and execute permissions;
- the silent discard of out-of-range indices and the unused field code;
- the one-cycle delay of a write.

A behavioural model in the bench covers both bound modes and is compared on every clock.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

    localparam int ADDR_W   = 32;
    localparam int GRAIN_LG = 6;
    localparam int UNIT_W   = ADDR_W - GRAIN_LG;
    localparam int IDX_W    = 5;
    localparam int MAX_REG  = 1 << IDX_W;

    typedef enum logic [1:0] {
        FLD_BASE  = 2'd0,
        FLD_BOUND = 2'd1,
        FLD_CTRL  = 2'd2,
        FLD_RSVD  = 2'd3
    } cfg_fld_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    typedef enum logic {
        BOUND_LIMIT = 1'b0,
        BOUND_SIZE  = 1'b1
    } bound_mode_e;

    typedef struct packed {
        logic              en;
        logic              perm_a;   // read or execute
        logic              perm_w;   // write
        logic [UNIT_W-1:0] base_u;   // base in 64-byte units
        logic [ADDR_W-1:0] bound;    // limit address or log2 size
    } rgn_cfg_t;

    typedef struct packed {
        logic             hit;
        logic             fault;
        logic [IDX_W-1:0] idx;
    } chk_res_t;

    // Mask over 64-byte units selecting the bits that must agree with the base.
    function automatic logic [UNIT_W-1:0] size_mask(input logic [5:0] lg);
        logic [UNIT_W-1:0] m;
        if (lg <= 6'(GRAIN_LG))
            m = '1;
        else if (lg >= 6'(ADDR_W))
            m = '0;
        else
            m = {UNIT_W{1'b1}} << (lg - 6'(GRAIN_LG));
        return m;
    endfunction

    function automatic logic perm_ok(input rgn_cfg_t r, input acc_kind_e k);
        return (k == ACC_STORE) ? r.perm_w : r.perm_a;
    endfunction

endpackage

// File: rtl/rgn_table.sv
module rgn_table
    import rgn_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  cfg_fld_e          wr_fld,
    input  logic [ADDR_W-1:0] wr_data,
    output rgn_cfg_t          regs [N]
);

    generate
        for (genvar g = 0; g < N; g++) begin : g_ent
            logic sel;
            assign sel = wr_en && (wr_idx == IDX_W'(g));

            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[g] <= '0;
                end else if (sel) begin
                    case (wr_fld)
                        FLD_BASE:  regs[g].base_u <= wr_data[ADDR_W-1:GRAIN_LG];
                        FLD_BOUND: regs[g].bound  <= wr_data;
                        FLD_CTRL: begin
                            regs[g].en     <= wr_data[0];
                            regs[g].perm_a <= wr_data[1];
                            regs[g].perm_w <= wr_data[2];
                        end
                        default: ;
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rgn_match.sv
module rgn_match
    import rgn_pkg::*;
#(
    parameter bound_mode_e BOUND_MODE = BOUND_LIMIT
) (
    input  rgn_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              match
);

    generate
        if (BOUND_MODE == BOUND_LIMIT) begin : g_limit
            logic [ADDR_W-1:0] lo;
            assign lo    = {cfg.base_u, {GRAIN_LG{1'b0}}};
            assign match = cfg.en && (addr >= lo) && (addr < cfg.bound);
        end else begin : g_size
            logic [UNIT_W-1:0] mask;
            logic [UNIT_W-1:0] diff;
            logic              unused_bits;
            assign mask        = size_mask(cfg.bound[5:0]);
            assign diff        = addr[ADDR_W-1:GRAIN_LG] ^ cfg.base_u;
            assign match       = cfg.en && ((diff & mask) == '0);
            assign unused_bits = ^{cfg.bound[ADDR_W-1:6], addr[GRAIN_LG-1:0]};
        end
    endgenerate

endmodule

// File: rtl/rgn_pick.sv
module rgn_pick
    import rgn_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [N-1:0]     first,
    output logic [IDX_W-1:0] idx
);

    assign any = |hits;

    always_comb begin
        first = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                first    = '0;
                first[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rgn_side.sv
module rgn_side
    import rgn_pkg::*;
#(
    parameter int          N          = 8,
    parameter bound_mode_e BOUND_MODE = BOUND_LIMIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  cfg_fld_e          wr_fld,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              acc_valid,
    input  acc_kind_e         acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    output chk_res_t          res
);

    rgn_cfg_t         regs [N];
    logic [N-1:0]     hits;
    logic [N-1:0]     perm_vec;
    logic [N-1:0]     first;
    logic             any;
    logic [IDX_W-1:0] idx;

    rgn_table #(.N(N)) table_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_fld  (wr_fld),
        .wr_data (wr_data),
        .regs    (regs)
    );

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            rgn_match #(.BOUND_MODE(BOUND_MODE)) match_i (
                .cfg   (regs[g]),
                .addr  (acc_addr),
                .match (hits[g])
            );
            assign perm_vec[g] = perm_ok(regs[g], acc_kind);
        end
    endgenerate

    rgn_pick #(.N(N)) pick_i (
        .hits  (hits),
        .any   (any),
        .first (first),
        .idx   (idx)
    );

    always_comb begin
        res.hit   = any;
        res.idx   = idx;
        res.fault = acc_valid && (!any || !(|(first & perm_vec)));
    end

endmodule

// File: rtl/region_guard.sv
module region_guard
    import rgn_pkg::*;
#(
    parameter int          NUM_IREG   = 8,
    parameter int          NUM_DREG   = 8,
    parameter bound_mode_e BOUND_MODE = BOUND_LIMIT
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_dside,
    input  logic [4:0]  cfg_idx,
    input  logic [1:0]  cfg_fld,
    input  logic [31:0] cfg_wdata,
    input  logic        ins_valid,
    input  logic [31:0] ins_addr,
    output logic        ins_hit,
    output logic        ins_fault,
    output logic [4:0]  ins_idx,
    input  logic        dat_valid,
    input  logic        dat_store,
    input  logic [31:0] dat_addr,
    output logic        dat_hit,
    output logic        dat_fault,
    output logic [4:0]  dat_idx
);

    localparam int I_DEPTH = (NUM_IREG > MAX_REG) ? MAX_REG : NUM_IREG;
    localparam int D_DEPTH = (NUM_DREG > MAX_REG) ? MAX_REG : NUM_DREG;

    cfg_fld_e  fld;
    acc_kind_e dkind;
    chk_res_t  ires;
    chk_res_t  dres;

    assign fld   = cfg_fld_e'(cfg_fld);
    assign dkind = dat_store ? ACC_STORE : ACC_LOAD;

    rgn_side #(.N(I_DEPTH), .BOUND_MODE(BOUND_MODE)) iside_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we && !cfg_dside),
        .wr_idx    (cfg_idx),
        .wr_fld    (fld),
        .wr_data   (cfg_wdata),
        .acc_valid (ins_valid),
        .acc_kind  (ACC_FETCH),
        .acc_addr  (ins_addr),
        .res       (ires)
    );

    rgn_side #(.N(D_DEPTH), .BOUND_MODE(BOUND_MODE)) dside_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we && cfg_dside),
        .wr_idx    (cfg_idx),
        .wr_fld    (fld),
        .wr_data   (cfg_wdata),
        .acc_valid (dat_valid),
        .acc_kind  (dkind),
        .acc_addr  (dat_addr),
        .res       (dres)
    );

    assign ins_hit   = ires.hit;
    assign ins_fault = ires.fault;
    assign ins_idx   = ires.idx;
    assign dat_hit   = dres.hit;
    assign dat_fault = dres.fault;
    assign dat_idx   = dres.idx;

endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
    parameter int NUM_IREG = 8,
    parameter int NUM_DREG = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic        ins_valid,
    input logic [31:0] ins_addr,
    input logic        ins_hit,
    input logic        ins_fault,
    input logic [4:0]  ins_idx,
    input logic        dat_valid,
    input logic        dat_store,
    input logic [31:0] dat_addr,
    input logic        dat_hit,
    input logic        dat_fault,
    input logic [4:0]  dat_idx
);

    AST_IDLE_NO_IFAULT: assert property (@(posedge clk) disable iff (rst)
        !ins_valid |-> !ins_fault); // R10
    AST_IDLE_NO_DFAULT: assert property (@(posedge clk) disable iff (rst)
        !dat_valid |-> !dat_fault); // R10
    AST_IMISS_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !ins_hit) |-> ins_fault); // R6
    AST_DMISS_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (dat_valid && !dat_hit) |-> dat_fault); // R6
    AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!ins_hit |-> ins_idx == 5'd0) and (!dat_hit |-> dat_idx == 5'd0)); // R6
    AST_IDX_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
        (ins_hit |-> int'(ins_idx) < NUM_IREG) and (dat_hit |-> int'(dat_idx) < NUM_DREG)); // R5
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ins_hit && !dat_hit)); // R1
    AST_CFG_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_we) && $stable(ins_addr) && $stable(dat_addr)
         && $stable(dat_store))
        |-> ($stable(ins_hit) && $stable(ins_idx) && $stable(dat_hit) && $stable(dat_idx))); // R11

endmodule

bind region_guard region_guard_chk #(.NUM_IREG(NUM_IREG), .NUM_DREG(NUM_DREG)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .ins_valid (ins_valid),
    .ins_addr  (ins_addr),
    .ins_hit   (ins_hit),
    .ins_fault (ins_fault),
    .ins_idx   (ins_idx),
    .dat_valid (dat_valid),
    .dat_store (dat_store),
    .dat_addr  (dat_addr),
    .dat_hit   (dat_hit),
    .dat_fault (dat_fault),
    .dat_idx   (dat_idx)
);

// File: tb/region_guard_tb_top.sv
`timescale 1ns/1ps
module region_guard_tb_top;

    localparam int NREG = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        cfg_we_l = 1'b0, cfg_we_s = 1'b0, cfg_dside = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [1:0]  cfg_fld = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ins_valid = 1'b0, dat_valid = 1'b0, dat_store = 1'b0;
    logic [31:0] ins_addr = '0, dat_addr = '0;

    logic        ih_l, if_l, dh_l, df_l, ih_s, if_s, dh_s, df_s;
    logic [4:0]  ii_l, di_l, ii_s, di_s;

    region_guard #(.NUM_IREG(NREG), .NUM_DREG(NREG), .BOUND_MODE(rgn_pkg::BOUND_LIMIT)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we_l), .cfg_dside(cfg_dside), .cfg_idx(cfg_idx),
        .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata), .ins_valid(ins_valid), .ins_addr(ins_addr),
        .ins_hit(ih_l), .ins_fault(if_l), .ins_idx(ii_l), .dat_valid(dat_valid),
        .dat_store(dat_store), .dat_addr(dat_addr), .dat_hit(dh_l), .dat_fault(df_l),
        .dat_idx(di_l));

    region_guard #(.NUM_IREG(NREG), .NUM_DREG(NREG), .BOUND_MODE(rgn_pkg::BOUND_SIZE)) dut_s (
        .clk(clk), .rst(rst), .cfg_we(cfg_we_s), .cfg_dside(cfg_dside), .cfg_idx(cfg_idx),
        .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata), .ins_valid(ins_valid), .ins_addr(ins_addr),
        .ins_hit(ih_s), .ins_fault(if_s), .ins_idx(ii_s), .dat_valid(dat_valid),
        .dat_store(dat_store), .dat_addr(dat_addr), .dat_hit(dh_s), .dat_fault(df_s),
        .dat_idx(di_s));

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural model: [dut 0 limit / 1 size][side 0 instr / 1 data][region]
    logic [31:0] m_base  [2][2][NREG];
    logic [31:0] m_bound [2][2][NREG];
    logic [2:0]  m_ctl   [2][2][NREG];

    always @(posedge clk) begin
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 2; s++) begin
                for (int r = 0; r < NREG; r++) begin
                    if (rst) begin
                        m_base[d][s][r]  = '0;
                        m_bound[d][s][r] = '0;
                        m_ctl[d][s][r]   = '0;
                    end else if (((d == 0) ? cfg_we_l : cfg_we_s) && (int'(cfg_dside) == s)
                                 && (int'(cfg_idx) == r)) begin
                        case (cfg_fld)
                            2'd0: m_base[d][s][r]  = cfg_wdata & 32'hFFFF_FFC0;
                            2'd1: m_bound[d][s][r] = cfg_wdata;
                            2'd2: m_ctl[d][s][r]   = cfg_wdata[2:0];
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    function automatic logic [6:0] predict(input int d, input int s, input logic [31:0] a,
                                           input bit store, input bit valid);
        bit hit = 0;
        int idx = 0;
        bit perm = 0;
        for (int r = 0; r < NREG; r++) begin
            bit m = 0;
            if (m_ctl[d][s][r][0]) begin
                if (d == 0) begin
                    m = (a >= m_base[d][s][r]) && (a < m_bound[d][s][r]);
                end else begin
                    int e = int'(m_bound[d][s][r][5:0]);
                    if (e < 6) e = 6;
                    if (e >= 32) m = 1;
                    else m = ((a >> e) == (m_base[d][s][r] >> e));
                end
            end
            if (m && !hit) begin
                hit  = 1;
                idx  = r;
                perm = store ? m_ctl[d][s][r][2] : m_ctl[d][s][r][1];
            end
        end
        return {hit, valid && (!hit || !perm), 5'(idx)};
    endfunction

    // Per-cycle comparison against the model, both bound modes (R10 same-cycle result)
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [6:0] e;
            e = predict(0, 0, ins_addr, 1'b0, ins_valid);
            chk({ih_l, if_l, ii_l} == e, "R10", "model limit instr", {ih_l, if_l, ii_l}, e);
            e = predict(0, 1, dat_addr, dat_store, dat_valid);
            chk({dh_l, df_l, di_l} == e, "R10", "model limit data", {dh_l, df_l, di_l}, e);
            e = predict(1, 0, ins_addr, 1'b0, ins_valid);
            chk({ih_s, if_s, ii_s} == e, "R10", "model size instr", {ih_s, if_s, ii_s}, e);
            e = predict(1, 1, dat_addr, dat_store, dat_valid);
            chk({dh_s, df_s, di_s} == e, "R10", "model size data", {dh_s, df_s, di_s}, e);
        end
    end

    task automatic wr(input bit to_l, input bit to_s, input bit dside, input int idx,
                      input int fld, input logic [31:0] v);
        @(posedge clk); #1;
        cfg_we_l = to_l; cfg_we_s = to_s; cfg_dside = dside;
        cfg_idx = 5'(idx); cfg_fld = 2'(fld); cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we_l = 1'b0; cfg_we_s = 1'b0;
    endtask

    task automatic fetch(input logic [31:0] a);
        @(posedge clk); #1;
        ins_valid = 1'b1; ins_addr = a; dat_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic daccess(input logic [31:0] a, input bit st);
        @(posedge clk); #1;
        dat_valid = 1'b1; dat_addr = a; dat_store = st; ins_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic exp_i(input string req, input bit sz, input bit h, input int idx, input bit f);
        logic [6:0] act;
        act = sz ? {ih_s, if_s, ii_s} : {ih_l, if_l, ii_l};
        chk(act == {h, f, 5'(idx)}, req, "instr {hit,fault,idx}", act, {h, f, 5'(idx)});
    endtask

    task automatic exp_d(input string req, input bit sz, input bit h, input int idx, input bit f);
        logic [6:0] act;
        act = sz ? {dh_s, df_s, di_s} : {dh_l, df_l, di_l};
        chk(act == {h, f, 5'(idx)}, req, "data {hit,fault,idx}", act, {h, f, 5'(idx)});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: empty tables after reset
        fetch(32'h0000_0100);
        exp_i("R1", 0, 0, 0, 1); exp_i("R1", 1, 0, 0, 1);
        daccess(32'h0000_0100, 1'b0);
        exp_d("R1", 0, 0, 0, 1); exp_d("R1", 1, 0, 0, 1);

        // R3: limit-mode instruction region 0 = [0x1000, 0x2000), execute
        wr(1, 0, 0, 0, 0, 32'h0000_1000);
        wr(1, 0, 0, 0, 1, 32'h0000_2000);
        wr(1, 0, 0, 0, 2, 32'h3);
        fetch(32'h0000_1000); exp_i("R3", 0, 1, 0, 0);
        fetch(32'h0000_1FFC); exp_i("R3", 0, 1, 0, 0);
        fetch(32'h0000_2000); exp_i("R3", 0, 0, 0, 1);
        fetch(32'h0000_0FC0); exp_i("R3", 0, 0, 0, 1);

        // R2: data table still empty, instruction region not consulted
        daccess(32'h0000_1800, 1'b0); exp_d("R2", 0, 0, 0, 1);

        // R5/R7: overlapping data regions 2 [0x1000,0x3000) read, 1 [0x1800,0x1C00) rw
        wr(1, 0, 1, 2, 0, 32'h0000_1000);
        wr(1, 0, 1, 2, 1, 32'h0000_3000);
        wr(1, 0, 1, 2, 2, 32'h3);
        wr(1, 0, 1, 1, 0, 32'h0000_1800);
        wr(1, 0, 1, 1, 1, 32'h0000_1C00);
        wr(1, 0, 1, 1, 2, 32'h7);
        daccess(32'h0000_1900, 1'b0); exp_d("R5", 0, 1, 1, 0);
        daccess(32'h0000_1900, 1'b1); exp_d("R7", 0, 1, 1, 0);
        daccess(32'h0000_2800, 1'b1); exp_d("R7", 0, 1, 2, 1);
        daccess(32'h0000_2800, 1'b0); exp_d("R7", 0, 1, 2, 0);

        // R8: disable region 1, permissions kept
        wr(1, 0, 1, 1, 2, 32'h6);
        daccess(32'h0000_1900, 1'b1); exp_d("R8", 0, 1, 2, 1);

        // R11: write visible only after the capturing edge
        @(posedge clk); #1;
        cfg_we_l = 1'b1; cfg_dside = 1'b1; cfg_idx = 5'd1; cfg_fld = 2'd2; cfg_wdata = 32'h7;
        dat_valid = 1'b1; dat_store = 1'b1; dat_addr = 32'h0000_1900;
        @(negedge clk); exp_d("R11", 0, 1, 2, 1);
        @(posedge clk); #1 cfg_we_l = 1'b0;
        @(negedge clk); exp_d("R11", 0, 1, 1, 0);

        // R9: out-of-range index and unused field code are dropped
        wr(1, 0, 1, 9, 2, 32'h0);
        daccess(32'h0000_1900, 1'b1); exp_d("R9", 0, 1, 1, 0);
        wr(1, 0, 1, 1, 3, 32'h0);
        daccess(32'h0000_1900, 1'b1); exp_d("R9", 0, 1, 1, 0);

        // R7: instruction region without execute bit
        wr(1, 0, 0, 3, 0, 32'h0000_4000);
        wr(1, 0, 0, 3, 1, 32'h0000_5000);
        wr(1, 0, 0, 3, 2, 32'h1);
        fetch(32'h0000_4100); exp_i("R7", 0, 1, 3, 1);

        // R4: size mode, 4 KiB region at 0x8000 and clamped 64-byte region at 0x100
        wr(0, 1, 0, 0, 0, 32'h0000_8000);
        wr(0, 1, 0, 0, 1, 32'd12);
        wr(0, 1, 0, 0, 2, 32'h3);
        wr(0, 1, 0, 1, 0, 32'h0000_0100);
        wr(0, 1, 0, 1, 1, 32'd2);
        wr(0, 1, 0, 1, 2, 32'h3);
        fetch(32'h0000_8FFC); exp_i("R4", 1, 1, 0, 0);
        fetch(32'h0000_9000); exp_i("R4", 1, 0, 0, 1);
        fetch(32'h0000_013C); exp_i("R4", 1, 1, 1, 0);
        fetch(32'h0000_0140); exp_i("R6", 1, 0, 0, 1);

        // R4/R7: whole-space read-only data region in size mode
        wr(0, 1, 1, 0, 1, 32'd32);
        wr(0, 1, 1, 0, 2, 32'h3);
        daccess(32'hDEAD_BEEC, 1'b1); exp_d("R7", 1, 1, 0, 1);
        daccess(32'hDEAD_BEEC, 1'b0); exp_d("R4", 1, 1, 0, 0);

        // R10: no fault while idle, hit still follows the address
        @(posedge clk); #1;
        ins_valid = 1'b0; ins_addr = 32'h0000_9000; dat_valid = 1'b0;
        @(negedge clk);
        exp_i("R10", 0, 0, 0, 0);
        exp_i("R10", 1, 0, 0, 0);
        @(posedge clk); #1 ins_addr = 32'h0000_1004;
        @(negedge clk); exp_i("R10", 0, 1, 0, 0);

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule